// File: doc/BRIEF.md
# UART interrupt enable and identification

This block sits beside the transmit and receive engines of a UART. It holds the interrupt enable register and the sticky receiver error flags. It also combines the interrupt conditions raised by the rest of the UART into one interrupt request line and one identification code. Software writes the enable register to switch the whole UART on or off and to choose which interrupt classes may reach the system interrupt controller. The identification register then tells software which pending cause to service first.

The enable register has three parts:
- a unit-enable bit, which is also driven out to the other UART blocks;
- five per-class interrupt enables;
- two reserved bits.

Receiver error pulses are collected into five sticky flags. The flags stay set until software reads the line status, and while any of them is set the line status interrupt class is pending. All other classes are level conditions that come from the FIFO and modem logic. The request output and the identification code are registered, so they take effect one clock after the state that produces them.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00. A write stores bit 6 and bits 4:0 of the written byte. Bits 7 and 5 always read 0.
- R2: `unit_en_o` equals enable bit 6. While it is 0, `irq_o` is 0 and `iir_o` is 0x01, whatever the conditions are.
- R3: While the unit is disabled, error pulses on `rx_err_i` do not set any sticky flag.
- R4: Each bit of `rx_err_i` sets its own sticky flag in `lsr_flags_o`, and the flag holds until a line status read. Bit positions are: 0 overrun, 1 parity, 2 framing, 3 break, 4 FIFO error.
- R5: A line status read (`lsr_rd_i`) clears all sticky flags at the next edge. An error arriving in the same cycle as the read is kept.
- R6: When no enabled class is pending, `iir_o` is 0x01 and `irq_o` is 0. When any enabled class is pending, `irq_o` is 1 and `iir_o` bit 0 is 0.
- R7: The identification code names the single highest-priority pending class, from highest to lowest:
  - line status (any sticky flag set): 0x06
  - receive data available: 0x04
  - receiver timeout: 0x0C
  - transmit data request: 0x02
  - modem status: 0x00
- R8: Each class is gated by its own enable bit:
  - bit 0: receive data
  - bit 1: transmit request
  - bit 2: line status
  - bit 3: modem status
  - bit 4: receiver timeout
- R9: `irq_o` and `iir_o` reflect the enable register, the sticky flags and the level inputs as they stood in the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_we_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| ier_rdata_o | output | 8 | Enable register read data |
| rx_err_i | input | 5 | Receiver error pulses (overrun, parity, framing, break, FIFO error) |
| lsr_rd_i | input | 1 | Line status read strobe; clears the sticky flags |
| lsr_flags_o | output | 5 | Sticky receiver error flags |
| rx_avail_i | input | 1 | Receive data available condition |
| rx_timeout_i | input | 1 | Receiver timeout condition |
| tx_req_i | input | 1 | Transmit data request condition |
| modem_chg_i | input | 1 | Modem status change condition |
| iir_o | output | 8 | Interrupt identification code |
| unit_en_o | output | 1 | UART unit enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases:
- **Read and error in the same cycle.** A design that let the clear win would drop the new error and never raise the line status interrupt for it.
- **Error pulses while the unit is disabled.** A design that still captured them would raise a stale interrupt the moment the unit is re-enabled.
- **Classes pending at the same time.** Two or more classes are driven together, so a wrong priority order or a swapped enable bit shows up as a wrong identification code.
- **Writes to the reserved bits and toggling of the unit enable while conditions are active.** These catch a read-back of bits 7 or 5 and a request that leaks out while the unit is off.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned NUM_ERR = 5;
  localparam int unsigned UEN_BIT = 6;
  localparam logic [REG_W-1:0] IER_WMASK = 8'h5F;
  localparam logic [REG_W-1:0] IIR_NONE  = 8'h01;

  // source index = priority rank, 0 is highest
  typedef enum logic [2:0] {
    SRC_LS  = 3'd0,
    SRC_RXD = 3'd1,
    SRC_RTO = 3'd2,
    SRC_TXR = 3'd3,
    SRC_MDM = 3'd4
  } irq_src_e;

  function automatic int unsigned src_ier_bit(int unsigned src);
    case (src)
      0:       return 2;
      1:       return 0;
      2:       return 4;
      3:       return 1;
      default: return 3;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] src_iir_code(int unsigned src);
    case (src)
      0:       return 8'h06;
      1:       return 8'h04;
      2:       return 8'h0C;
      3:       return 8'h02;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/uart_ier_reg.sv
module uart_ier_reg
  import uart_irq_pkg::*;
#(
  parameter int unsigned W = REG_W,
  parameter int unsigned N = NUM_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         unit_en_o,
  output logic [N-1:0] src_en_o
);
  logic [W-1:0] ier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ier_q <= '0;
    else if (we_i) ier_q <= wdata_i & W'(IER_WMASK);
  end

  assign rdata_o   = ier_q;
  assign unit_en_o = ier_q[UEN_BIT];

  // reorder enable bits into priority-ranked source order
  for (genvar s = 0; s < N; s++) begin : g_map
    localparam int unsigned B = src_ier_bit(s);
    assign src_en_o[s] = ier_q[B];
  end
endmodule

// File: rtl/uart_ls_sticky.sv
module uart_ls_sticky #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_en_i,
  input  logic [N-1:0] err_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o,
  output logic         any_o
);
  for (genvar b = 0; b < N; b++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= (flag_q & ~clr_i) | (err_i[b] & cap_en_i);
    end
    assign flags_o[b] = flag_q;
  end

  assign any_o = |flags_o;
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
  import uart_irq_pkg::*;
#(
  parameter int unsigned N = NUM_SRC,
  parameter int unsigned W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  output logic         irq_o,
  output logic [W-1:0] iir_o
);
  logic [W-1:0] code_d;
  logic [W-1:0] iir_q;
  logic         irq_q;

  always_comb begin
    code_d = W'(IIR_NONE);
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) code_d = W'(src_iir_code(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      iir_q <= W'(IIR_NONE);
    end else begin
      irq_q <= |pend_i;
      iir_q <= code_d;
    end
  end

  assign irq_o = irq_q;
  assign iir_o = iir_q;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ier_we_i,
  input  logic [7:0]   ier_wdata_i,
  output logic [7:0]   ier_rdata_o,
  input  logic [4:0]   rx_err_i,
  input  logic         lsr_rd_i,
  output logic [4:0]   lsr_flags_o,
  input  logic         rx_avail_i,
  input  logic         rx_timeout_i,
  input  logic         tx_req_i,
  input  logic         modem_chg_i,
  output logic [7:0]   iir_o,
  output logic         unit_en_o,
  output logic         irq_o
);
  logic [NUM_SRC-1:0] src_en;
  logic [NUM_SRC-1:0] src_raw;
  logic [NUM_SRC-1:0] src_pend;
  logic               ls_any;

  uart_ier_reg #(.W(REG_W), .N(NUM_SRC)) u_ier (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ier_we_i),
    .wdata_i  (ier_wdata_i),
    .rdata_o  (ier_rdata_o),
    .unit_en_o(unit_en_o),
    .src_en_o (src_en)
  );

  uart_ls_sticky #(.N(NUM_ERR)) u_ls (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_en_i(unit_en_o),
    .err_i   (rx_err_i),
    .clr_i   (lsr_rd_i),
    .flags_o (lsr_flags_o),
    .any_o   (ls_any)
  );

  always_comb begin
    src_raw          = '0;
    src_raw[SRC_LS]  = ls_any;
    src_raw[SRC_RXD] = rx_avail_i;
    src_raw[SRC_RTO] = rx_timeout_i;
    src_raw[SRC_TXR] = tx_req_i;
    src_raw[SRC_MDM] = modem_chg_i;
  end

  assign src_pend = src_raw & src_en & {NUM_SRC{unit_en_o}};

  uart_irq_arb #(.N(NUM_SRC), .W(REG_W)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pend_i(src_pend),
    .irq_o (irq_o),
    .iir_o (iir_o)
  );
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] ier_rdata_o,
  input logic [4:0] rx_err_i,
  input logic       lsr_rd_i,
  input logic [4:0] lsr_flags_o,
  input logic [7:0] iir_o,
  input logic       unit_en_o,
  input logic       irq_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_rdata_o[7] == 1'b0) && (ier_rdata_o[5] == 1'b0)); // R1

  AST_OFF_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unit_en_o |=> !irq_o); // R2

  AST_OFF_NO_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unit_en_o && lsr_flags_o == 5'd0) |=> lsr_flags_o == 5'd0); // R3

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lsr_rd_i |=> (lsr_flags_o & $past(lsr_flags_o)) == $past(lsr_flags_o)); // R4

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && rx_err_i == 5'd0) |=> lsr_flags_o == 5'd0); // R5

  AST_IDLE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> iir_o == 8'h01); // R6

  AST_LS_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_en_o && ier_rdata_o[2] && lsr_flags_o != 5'd0) |=> (irq_o && iir_o == 8'h06)); // R7
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ier_rdata_o(ier_rdata_o),
  .rx_err_i   (rx_err_i),
  .lsr_rd_i   (lsr_rd_i),
  .lsr_flags_o(lsr_flags_o),
  .iir_o      (iir_o),
  .unit_en_o  (unit_en_o),
  .irq_o      (irq_o)
);

// File: tb/uart_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ier_we = 1'b0;
  logic [7:0] ier_wdata = '0;
  logic [7:0] ier_rdata;
  logic [4:0] rx_err = '0;
  logic       lsr_rd = 1'b0;
  logic [4:0] lsr_flags;
  logic       rx_avail = 1'b0, rx_timeout = 1'b0, tx_req = 1'b0, modem_chg = 1'b0;
  logic [7:0] iir;
  logic       unit_en, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  uart_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ier_we_i(ier_we), .ier_wdata_i(ier_wdata), .ier_rdata_o(ier_rdata),
    .rx_err_i(rx_err), .lsr_rd_i(lsr_rd), .lsr_flags_o(lsr_flags),
    .rx_avail_i(rx_avail), .rx_timeout_i(rx_timeout), .tx_req_i(tx_req),
    .modem_chg_i(modem_chg), .iir_o(iir), .unit_en_o(unit_en), .irq_o(irq)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h @%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_ier = 0, m_lsr = 0, m_iir = 1, m_irq = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ier = 0; m_lsr = 0; m_iir = 1; m_irq = 0;
    end else begin
      bit en, p_ls, p_rd, p_to, p_tx, p_md;
      en   = m_ier[6];
      p_ls = en && m_ier[2] && (m_lsr != 0);
      p_rd = en && m_ier[0] && rx_avail;
      p_to = en && m_ier[4] && rx_timeout;
      p_tx = en && m_ier[1] && tx_req;
      p_md = en && m_ier[3] && modem_chg;
      if (p_ls)      m_iir = 'h06;
      else if (p_rd) m_iir = 'h04;
      else if (p_to) m_iir = 'h0C;
      else if (p_tx) m_iir = 'h02;
      else if (p_md) m_iir = 'h00;
      else           m_iir = 'h01;
      m_irq = p_ls || p_rd || p_to || p_tx || p_md;
      m_lsr = (lsr_rd ? 0 : m_lsr) | (en ? int'(rx_err) : 0);
      if (ier_we) m_ier = ier_wdata & 'h5F;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1", "ier_rdata", ier_rdata, m_ier);
      check("R2", "unit_en", unit_en, m_ier[6]);
      check("R4", "lsr_flags", lsr_flags, m_lsr);
      check("R6", "irq", irq, m_irq);
      check("R7", "iir", iir, m_iir);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr_ier(logic [7:0] v);
    ier_we = 1'b1; ier_wdata = v; cyc(); ier_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check("R1", "reset ier", ier_rdata, 'h00);
    check("R6", "reset iir", iir, 'h01);
    check("R6", "reset irq", irq, 0);

    // R1 reserved bits dropped
    wr_ier(8'hFF);
    check("R1", "ier after 0xFF", ier_rdata, 'h5F);
    check("R2", "unit_en on", unit_en, 1);

    // R2 / R3 disabled: conditions and errors have no effect
    wr_ier(8'h1F);
    rx_avail = 1; tx_req = 1; rx_err = 5'h1F;
    cyc();
    rx_err = 0;
    cyc();
    check("R3", "flags while off", lsr_flags, 0);
    check("R2", "irq while off", irq, 0);
    check("R2", "iir while off", iir, 'h01);
    rx_avail = 0; tx_req = 0;

    // R8 / R9 receive data only
    wr_ier(8'h45);
    rx_avail = 1;
    cyc();
    check("R9", "iir one cycle after rx_avail", iir, 'h04);
    // R4 framing sets bit 2, then R7 line status wins
    rx_err = 5'b00100;
    cyc();
    rx_err = 0;
    check("R4", "framing flag", lsr_flags, 'h04);
    cyc();
    check("R7", "line status wins", iir, 'h06);
    // R5 read with simultaneous parity error
    lsr_rd = 1; rx_err = 5'b00010;
    cyc();
    lsr_rd = 0; rx_err = 0;
    check("R5", "error kept across read", lsr_flags, 'h02);
    lsr_rd = 1;
    cyc();
    lsr_rd = 0;
    check("R5", "read clears", lsr_flags, 0);
    rx_avail = 0;

    // R8 tx request with its enable off
    tx_req = 1;
    cyc(2);
    check("R8", "masked tx", iir, 'h01);
    wr_ier(8'h42);
    cyc();
    check("R8", "tx enabled", iir, 'h02);
    // R7 timeout above tx, modem lowest
    wr_ier(8'h5A);
    rx_timeout = 1; modem_chg = 1;
    cyc(2);
    check("R7", "timeout over tx", iir, 'h0C);
    rx_timeout = 0; tx_req = 0;
    cyc(2);
    check("R7", "modem only", iir, 'h00);
    modem_chg = 0;

    // random traffic, model compared each cycle
    for (int i = 0; i < 4000; i++) begin
      ier_we     = ($urandom_range(0, 15) == 0);
      ier_wdata  = 8'($urandom) | (($urandom_range(0, 3) != 0) ? 8'h40 : 8'h00);
      rx_err     = ($urandom_range(0, 9) == 0) ? 5'($urandom) : 5'd0;
      lsr_rd     = ($urandom_range(0, 7) == 0);
      rx_avail   = 1'($urandom);
      rx_timeout = 1'($urandom);
      tx_req     = 1'($urandom);
      modem_chg  = 1'($urandom);
      cyc();
    end
    ier_we = 0; rx_err = 0; lsr_rd = 0;
    cyc(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule